// File: doc/BRIEF.md
# Power-of-Two Octave Clock Generator

This block turns a fast master clock into a pair of complementary clocks whose rate is chosen by a 4-bit octave code. The highest code passes the master clock through unchanged, and each lower code halves the rate. The output period at code k is therefore 2^(15-k) master cycles. The division comes from a free-running counter, and the output is taken from the counter bit that the code selects.

A 2-bit configuration input controls the outputs. It can run both outputs, gate either one low, or put the block to sleep. In sleep both outputs are low, the counter stops, and a flag is raised. A separate enable input forces both outputs low at once, without waiting for a clock edge.

A change of octave code is applied only at a master edge after which the newly selected counter bit is low. This prevents a runt pulse. Code 15 is always accepted, because its source is the master clock itself.

Top module: `octclk_gen`

## Requirements
- R1: For an applied octave code k below 15, `clk_main` has a period of 2^(15-k) master cycles and is high for exactly half of them.
- R2: With octave code 15 applied, `clk_main` follows the master clock: high in its high phase and low in its low phase.
- R3: When both outputs are enabled, `clk_aux` is always the inverse of `clk_main` (a 180-degree shift).
- R4: Configuration code 2'b00 runs both outputs. Code 2'b01 holds `clk_main` low and leaves `clk_aux` running. Code 2'b10 holds `clk_aux` low and leaves `clk_main` running.
- R5: Configuration code 2'b11 drives both outputs low and raises `pwr_down`. It also freezes the divider count, so that after leaving this state the phase resumes from where it stopped.
- R6: While `oe_async` is low, both outputs are low, including between master clock edges.
- R7: During and after reset, the applied octave is 0 and the count is 0, so `clk_main` is low, `clk_aux` is high and `pwr_down` is low (given configuration 2'b00 and `oe_async` high).
- R8: A requested octave code k below 15 becomes the applied code only at a master edge after which counter bit 14-k is 0. Code 15 is applied at the next edge. Until then the previous code stays in force.
- R9: Raising the octave code never lowers the output frequency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mst | input | 1 | Master clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| oct_sel | input | 4 | Requested octave code (15 = undivided) |
| out_cfg | input | 2 | Output configuration: 00 both, 01 aux only, 10 main only, 11 sleep |
| oe_async | input | 1 | Asynchronous enable; low forces both outputs low |
| clk_main | output | 1 | Main divided clock |
| clk_aux | output | 1 | Complement of the main clock |
| pwr_down | output | 1 | High while in the sleep configuration |

## Verification
The assertions sample at the master rising edge and take the configuration and octave inputs as steady around that edge. The stimulus therefore changes these inputs only on falling edges.

`oe_async` is the one input that is also moved between edges, to show that it acts at once. The edge-sampled properties for it assume only that the outputs read low whenever the enable reads low at an edge.

The per-cycle reference model samples shortly after each rising edge, in the master clock's high phase. The low phase of the undivided octave is checked separately at falling edges.

// File: rtl/octclk_pkg.sv
// Shared types for the octave clock generator.
package octclk_pkg;
    // Output configuration codes; the numeric values are decoded by the gate stage.
    typedef enum logic [1:0] {
        CFG_BOTH      = 2'b00,
        CFG_AUX_ONLY  = 2'b01,
        CFG_MAIN_ONLY = 2'b10,
        CFG_SLEEP     = 2'b11
    } out_cfg_e;
endpackage

// File: rtl/octclk_counter.sv
// Free-running divider counter.
// Counts master cycles and wraps at its width. It holds its value while halt is high.
// Assumes halt is synchronous to clk. Exposes both the present and the next count.
module octclk_counter #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt
);
    // Next count: hold while halted, otherwise increment.
    always_comb begin
        cnt_nxt = halt ? cnt_q : cnt_q + 1'b1;
    end

    // Count register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/octclk_select.sv
// Octave selection.
// Builds one tap per octave code: counter bits for the divided codes and the master
// clock for the top code. It holds the applied code in a register, which takes a new
// request only when the requested tap will be low after the edge, so that no runt
// pulse is produced.
// Assumes oct_req is steady around the rising edge of clk.
module octclk_select #(
    parameter int OCT_W = 4,
    localparam int NUM_OCT = 1 << OCT_W,
    localparam int CNT_W = NUM_OCT - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OCT_W-1:0] oct_req,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] cnt_nxt,
    output logic [OCT_W-1:0] act_oct,
    output logic             src_lvl
);
    logic [NUM_OCT-1:0] tap_now;
    logic [NUM_OCT-1:0] tap_next;
    logic               switch_ok;

    // Divided taps: code g reads counter bit CNT_W-1-g.
    for (genvar g = 0; g < CNT_W; g++) begin : g_tap
        assign tap_now[g]  = cnt_q[CNT_W-1-g];
        assign tap_next[g] = cnt_nxt[CNT_W-1-g];
    end

    // Top code bypasses the counter and is always safe to enter.
    assign tap_now[CNT_W]  = clk;
    assign tap_next[CNT_W] = 1'b0;

    // A switch is allowed when the new tap will be low after this edge.
    assign switch_ok = ~tap_next[oct_req];

    // Applied-code register.
    always_ff @(posedge clk) begin
        if (!rst_n)         act_oct <= '0;
        else if (switch_ok) act_oct <= oct_req;
    end

    // Source level of the applied code.
    assign src_lvl = tap_now[act_oct];
endmodule

// File: rtl/octclk_gate.sv
// Output gating.
// Derives the main clock and its complement from the selected source level, then
// applies the configuration code and the asynchronous enable. Purely combinational,
// so a low enable takes effect without a clock edge.
module octclk_gate
    import octclk_pkg::*;
(
    input  logic     src_lvl,
    input  out_cfg_e cfg,
    input  logic     oe,
    output logic     main_o,
    output logic     aux_o,
    output logic     sleep_o
);
    logic main_en;
    logic aux_en;

    // Per-output enables from the configuration code.
    always_comb begin
        main_en = (cfg == CFG_BOTH) || (cfg == CFG_MAIN_ONLY);
        aux_en  = (cfg == CFG_BOTH) || (cfg == CFG_AUX_ONLY);
        sleep_o = (cfg == CFG_SLEEP);
    end

    // Gated complementary outputs.
    always_comb begin
        main_o = src_lvl  & main_en & oe;
        aux_o  = ~src_lvl & aux_en  & oe;
    end
endmodule

// File: rtl/octclk_gen.sv
// Octave clock generator top.
// Divides clk_mst by 2^(CNT_W - applied code), or passes it through at the top code.
// Drives complementary outputs that are gated by the configuration code and the
// asynchronous enable. The sleep configuration halts the counter.
// Assumes oct_sel and out_cfg change away from the rising edge of clk_mst.
module octclk_gen #(
    parameter int OCT_W = 4,
    localparam int CNT_W = (1 << OCT_W) - 1
) (
    input  logic             clk_mst,
    input  logic             rst_n,
    input  logic [OCT_W-1:0] oct_sel,
    input  logic [1:0]       out_cfg,
    input  logic             oe_async,
    output logic             clk_main,
    output logic             clk_aux,
    output logic             pwr_down
);
    import octclk_pkg::*;

    out_cfg_e         cfg;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [OCT_W-1:0] act_oct;
    logic             src_lvl;
    logic             sleep_w;

    // Typed view of the configuration input.
    assign cfg = out_cfg_e'(out_cfg);

    octclk_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk_mst),
        .rst_n   (rst_n),
        .halt    (sleep_w),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    octclk_select #(.OCT_W(OCT_W)) u_sel (
        .clk     (clk_mst),
        .rst_n   (rst_n),
        .oct_req (oct_sel),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt),
        .act_oct (act_oct),
        .src_lvl (src_lvl)
    );

    octclk_gate u_gate (
        .src_lvl (src_lvl),
        .cfg     (cfg),
        .oe      (oe_async),
        .main_o  (clk_main),
        .aux_o   (clk_aux),
        .sleep_o (sleep_w)
    );

    assign pwr_down = sleep_w;
endmodule

// File: rtl/octclk_chk.sv
// Property checker for octclk_gen, attached with bind below.
// Samples on the master rising edge.
module octclk_chk #(
    parameter int OCT_W = 4,
    localparam int CNT_W = (1 << OCT_W) - 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       out_cfg,
    input logic             oe_async,
    input logic [OCT_W-1:0] act_oct,
    input logic [CNT_W-1:0] cnt_q,
    input logic             clk_main,
    input logic             clk_aux,
    input logic             pwr_down
);
    // R1: the divider advances by one each running cycle.
    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !pwr_down) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R3: complementary outputs when both are enabled.
    assert_complement_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_cfg == 2'b00 && oe_async) |-> (clk_main != clk_aux));

    // R4: main held low under configuration 01.
    assert_main_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_cfg == 2'b01) |-> !clk_main);

    // R4: aux held low under configuration 10.
    assert_aux_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_cfg == 2'b10) |-> !clk_aux);

    // R5: sleep silences both outputs.
    assert_sleep_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> (!clk_main && !clk_aux));

    // R5: sleep freezes the count.
    assert_sleep_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && pwr_down) |=> $stable(cnt_q));

    // R6: a low enable silences both outputs.
    assert_oe_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_async |-> (!clk_main && !clk_aux));

    // R8: a newly applied divided code starts with its tap low.
    assert_switch_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !$stable(act_oct) && act_oct != CNT_W[OCT_W-1:0])
            |-> (cnt_q[CNT_W-1-int'(act_oct)] == 1'b0));
endmodule

bind octclk_gen octclk_chk #(.OCT_W(OCT_W)) u_chk (
    .clk      (clk_mst),
    .rst_n    (rst_n),
    .out_cfg  (out_cfg),
    .oe_async (oe_async),
    .act_oct  (act_oct),
    .cnt_q    (cnt_q),
    .clk_main (clk_main),
    .clk_aux  (clk_aux),
    .pwr_down (pwr_down)
);

// File: tb/octclk_gen_tb.sv
module octclk_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] oct_sel = 4'd0;
    logic [1:0] out_cfg = 2'b00;
    logic       oe_async = 1'b1;
    logic       clk_main, clk_aux, pwr_down;

    int    n_chk = 0;
    int    n_fail = 0;
    string tag = "R7";
    bit    done = 1'b0;

    // Behavioural model state.
    int m_cnt = 0;
    int m_oct = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    octclk_gen u_dut (
        .clk_mst(clk), .rst_n(rst_n), .oct_sel(oct_sel), .out_cfg(out_cfg),
        .oe_async(oe_async), .clk_main(clk_main), .clk_aux(clk_aux), .pwr_down(pwr_down)
    );

    task automatic check(input string t, input string what, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", t, what, got, exp, $time);
        end
    endtask

    // Cycle model: update on each rising edge, compare in the high phase.
    always @(posedge clk) begin
        int nx;
        int lvl;
        int en;
        if (!rst_n) begin
            m_cnt = 0;
            m_oct = 0;
        end else begin
            nx = (out_cfg == 2'b11) ? m_cnt : (m_cnt + 1) % 32768;
            if (oct_sel == 4'd15 || ((nx >> (14 - int'(oct_sel))) & 1) == 0)
                m_oct = int'(oct_sel);
            m_cnt = nx;
        end
        #2;
        if (!done) begin
            lvl = (m_oct == 15) ? 1 : ((m_cnt >> (14 - m_oct)) & 1);
            en  = oe_async ? 1 : 0;
            check(tag, "clk_main", int'(clk_main),
                  (lvl == 1 && en == 1 && (out_cfg == 2'b00 || out_cfg == 2'b10)) ? 1 : 0);
            check(tag, "clk_aux", int'(clk_aux),
                  (lvl == 0 && en == 1 && (out_cfg == 2'b00 || out_cfg == 2'b01)) ? 1 : 0);
            check(tag, "pwr_down", int'(pwr_down), (out_cfg == 2'b11) ? 1 : 0);
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Measure period and high time of clk_main in master cycles.
    task automatic measure(output int per, output int hi);
        int prev;
        int cur;
        int guard;
        prev = 1; per = 0; hi = 0; guard = 0;
        forever begin
            @(posedge clk); #3; cur = int'(clk_main); guard++;
            if ((prev == 0 && cur == 1) || guard > 5000) break;
            prev = cur;
        end
        per = 1; hi = 1; prev = 1;
        forever begin
            @(posedge clk); #3; cur = int'(clk_main);
            if ((prev == 0 && cur == 1) || per > 5000) break;
            per++;
            if (cur == 1) hi++;
            prev = cur;
        end
    endtask

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int per;
        int hi;
        int last_per;

        // R7: reset state.
        tag = "R7";
        cycles(3);
        check("R7", "main in reset", int'(clk_main), 0);
        check("R7", "aux in reset", int'(clk_aux), 1);
        check("R7", "pwr_down in reset", int'(pwr_down), 0);
        rst_n = 1'b1;
        cycles(2);
        check("R7", "main after reset", int'(clk_main), 0);
        check("R7", "aux after reset", int'(clk_aux), 1);

        // R1: slowest octave through a full period (model compares every cycle).
        tag = "R1";
        cycles(33000);

        // R1 and R9: measured period and duty for octaves 9 to 14.
        last_per = 1 << 30;
        for (int k = 9; k <= 14; k++) begin
            @(negedge clk); oct_sel = 4'(k);
            cycles(1 << (16 - k));
            measure(per, hi);
            check("R1", $sformatf("period oct %0d", k), per, 1 << (15 - k));
            check("R1", $sformatf("high time oct %0d", k), hi, 1 << (14 - k));
            check("R9", $sformatf("monotonic oct %0d", k), (per < last_per) ? 1 : 0, 1);
            last_per = per;
        end

        // R2: undivided octave, low phase checked at falling edges.
        tag = "R2";
        @(negedge clk); oct_sel = 4'd15;
        cycles(2);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); #2;
            check("R2", "main low phase", int'(clk_main), 0);
            check("R2", "aux low phase", int'(clk_aux), 1);
        end

        // R8: octave changes at assorted times.
        tag = "R8";
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); oct_sel = 4'((i * 7 + 3) % 16);
            cycles((i % 5) * 13 + 3);
        end
        @(negedge clk); oct_sel = 4'd12;
        cycles(40);

        // R4 and R3: configuration gating.
        tag = "R4";
        @(negedge clk); out_cfg = 2'b01;
        cycles(100);
        @(negedge clk); out_cfg = 2'b10;
        cycles(100);
        tag = "R3";
        @(negedge clk); out_cfg = 2'b00;
        cycles(100);

        // R5: sleep freezes the phase.
        tag = "R5";
        @(negedge clk); oct_sel = 4'd13;
        cycles(9);
        @(negedge clk); out_cfg = 2'b11;
        cycles(57);
        @(negedge clk); out_cfg = 2'b00;
        cycles(60);

        // R6: asynchronous enable between edges.
        tag = "R6";
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #4; oe_async = 1'b0; #0.5;
            check("R6", "main forced low", int'(clk_main), 0);
            check("R6", "aux forced low", int'(clk_aux), 0);
            cycles(5);
            @(negedge clk); oe_async = 1'b1;
            cycles(7);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule